// File: doc/BRIEF.md
# Dual-Mode Operating System Timer

This block is a small memory-mapped timer peripheral holding two counters behind one register port. A free-running timestamp counter advances on every timer clock and can be cleared to zero by software. A tick timer counts down from a programmable timeout and raises a pending flag when it reaches zero. The pending flag drives the interrupt output and stays set until software clears it.

The tick timer's reload register also carries its two control bits in the lowest bit positions. Bit 0 enables the timer and bit 1 selects one-shot operation. The timeout is taken from bits [31:2], with its two lowest bits forced to zero. In periodic mode the timer reloads itself after each expiry. In one-shot mode it expires once and then stays idle until the reload register is written again. Clearing the enable bit freezes the countdown, so an operating system can use the timer both for a fixed tick rate and for programmed next-event deadlines.

Top module: `os_tick_timer`

## Requirements
- R1: After reset every register reads zero, the timer is disabled and `tick_irq` is low.
- R2: The timestamp at offset 0 increases by one on every clock edge that carries no write to offset 0, and it wraps modulo 2^CNT_W.
- R3: A write of any value to offset 0 sets the timestamp to zero on that edge, and counting resumes from zero on the next edge.
- R4: The reload register at offset 1 reads back exactly as written: bit 0 is enable, bit 1 is one-shot, and bits [CNT_W-1:2] are the timeout. The current countdown value reads at offset 2, and writes to offset 2 have no effect.
- R5: A write to offset 1 loads the countdown with the written timeout on that edge, with bits [1:0] taken as zero, whether or not the timer is running.
- R6: While the timer is enabled and not finished, the countdown decreases by one per clock. On the edge where it is found at zero, the timer expires. In periodic mode (bit 1 clear) the countdown then reloads the timeout, so expiries repeat every timeout+1 clocks.
- R7: In one-shot mode (bit 1 set) the timer expires exactly once, the countdown stays at zero, and no further expiry occurs until offset 1 is written again.
- R8: While bit 0 is clear the countdown holds its value. Writing the same timeout back with bit 0 set restarts counting from that timeout.
- R9: Bit 0 of offset 3 is the pending flag. It is set by an expiry and is cleared by writing a 1 to bit 0 of offset 3. Writing 0 there has no effect. If an expiry and a clear fall on the same edge, the flag stays set.
- R10: `tick_irq` goes high on the edge after an expiry and stays high exactly as long as the pending flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 2 | Register offset: 0 timestamp, 1 reload/control, 2 countdown, 3 status |
| bus_wdata | input | CNT_W (32) | Write data |
| bus_rdata | output | CNT_W (32) | Read data for `bus_addr`, combinational |
| tick_irq | output | 1 | Interrupt request, high while the pending flag is set |

## Verification
The embedded assertions check the rules that hold on every cycle. These are: the timestamp stepping or clearing, the countdown taking the masked value on a load, the countdown freezing while disabled, a periodic expiry reloading the timeout, a single expiry in one-shot mode, the pending flag holding or clearing, and the interrupt following an expiry. The bench's scenarios are the only way to show the properties that span many cycles. These include the exact period of timeout+1 clocks, the one-shot timer staying silent until it is rearmed, a disable and re-enable resuming with the same timeout, a reload taking effect in the middle of a countdown, writes of 0 and writes to the countdown offset changing nothing, and an expiry winning over a clear on the same edge.

// File: rtl/ost_pkg.sv
package ost_pkg;
   typedef enum logic [1:0] {
      REG_STAMP  = 2'd0,
      REG_RELOAD = 2'd1,
      REG_COUNT  = 2'd2,
      REG_STATUS = 2'd3
   } ost_reg_e;

   localparam int CTL_W    = 2;
   localparam int EN_BIT   = 0;
   localparam int ONE_BIT  = 1;
   localparam int PEND_BIT = 0;
endpackage

// File: rtl/ost_stamp.sv
module ost_stamp #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   output logic [W-1:0] stamp_o
);
   logic [W-1:0] stamp_q;

   if (W < 2) begin : g_bad_width
      $error("ost_stamp: W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   stamp_q <= '0;
      else if (clr) stamp_q <= '0;
      else          stamp_q <= stamp_q + W'(1);
   end

   assign stamp_o = stamp_q;

   a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> stamp_q == $past(stamp_q) + W'(1));
   a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> stamp_q == '0);
endmodule

// File: rtl/ost_tick.sv
module ost_tick #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] reload_o,
   output logic [W-1:0] count_o,
   output logic         expire_o
);
   import ost_pkg::*;

   logic [W-1:0] reload_q;
   logic [W-1:0] cnt_q;
   logic         done_q;
   logic [W-1:0] timeout;
   logic [W-1:0] load_timeout;
   logic         run;
   logic         at_zero;

   if (W < CTL_W + 2) begin : g_bad_width
      $error("ost_tick: W too small for control bits");
   end

   for (genvar b = 0; b < W; b++) begin : g_mask
      if (b < CTL_W) begin : g_ctl
         assign timeout[b]      = 1'b0;
         assign load_timeout[b] = 1'b0;
      end else begin : g_val
         assign timeout[b]      = reload_q[b];
         assign load_timeout[b] = load_val[b];
      end
   end

   assign run      = reload_q[EN_BIT] & ~done_q;
   assign at_zero  = (cnt_q == '0);
   assign expire_o = run & at_zero & ~load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_q <= '0;
         cnt_q    <= '0;
         done_q   <= 1'b0;
      end else if (load) begin
         reload_q <= load_val;
         cnt_q    <= load_timeout;
         done_q   <= 1'b0;
      end else if (run) begin
         if (at_zero) begin
            if (reload_q[ONE_BIT]) done_q <= 1'b1;
            else                   cnt_q  <= timeout;
         end else begin
            cnt_q <= cnt_q - W'(1);
         end
      end
   end

   assign reload_o = reload_q;
   assign count_o  = cnt_q;

   a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> cnt_q == {$past(load_val[W-1:CTL_W]), {CTL_W{1'b0}}});
   a_r6_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
      expire_o && !reload_q[ONE_BIT] |=> cnt_q == {reload_q[W-1:CTL_W], {CTL_W{1'b0}}});
   a_r7_single_expiry: assert property (@(posedge clk) disable iff (!rst_n)
      expire_o && reload_q[ONE_BIT] |=> !expire_o);
   a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !reload_q[EN_BIT] && !load |=> $stable(cnt_q));
endmodule

// File: rtl/ost_pend.sv
module ost_pend (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic pend_o
);
   logic pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pend_q <= 1'b0;
      else if (set) pend_q <= 1'b1;
      else if (clr) pend_q <= 1'b0;
   end

   assign pend_o = pend_q;

   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q && !clr |=> pend_q);
   a_r9_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      clr && !set |=> !pend_q);
   a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> pend_q);
endmodule

// File: rtl/os_tick_timer.sv
module os_tick_timer #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic [1:0]       bus_addr,
   input  logic [CNT_W-1:0] bus_wdata,
   output logic [CNT_W-1:0] bus_rdata,
   output logic             tick_irq
);
   import ost_pkg::*;

   ost_reg_e     sel;
   logic         wr_stamp, wr_reload, wr_status;
   logic [CNT_W-1:0] stamp, reload, count;
   logic         expire, pend, clr_pend;

   assign sel       = ost_reg_e'(bus_addr);
   assign wr_stamp  = bus_wr && (sel == REG_STAMP);
   assign wr_reload = bus_wr && (sel == REG_RELOAD);
   assign wr_status = bus_wr && (sel == REG_STATUS);
   assign clr_pend  = wr_status && bus_wdata[PEND_BIT];

   ost_stamp #(.W(CNT_W)) i_stamp (
      .clk(clk), .rst_n(rst_n), .clr(wr_stamp), .stamp_o(stamp));

   ost_tick #(.W(CNT_W)) i_tick (
      .clk(clk), .rst_n(rst_n), .load(wr_reload), .load_val(bus_wdata),
      .reload_o(reload), .count_o(count), .expire_o(expire));

   ost_pend i_pend (
      .clk(clk), .rst_n(rst_n), .set(expire), .clr(clr_pend), .pend_o(pend));

   always_comb begin
      bus_rdata = '0;
      case (sel)
         REG_STAMP:  bus_rdata = stamp;
         REG_RELOAD: bus_rdata = reload;
         REG_COUNT:  bus_rdata = count;
         REG_STATUS: bus_rdata[PEND_BIT] = pend;
         default:    bus_rdata = '0;
      endcase
   end

   assign tick_irq = pend;

   a_r10_irq_after_expiry: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> tick_irq);
   a_r10_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
      tick_irq && clr_pend && !expire |=> !tick_irq);
endmodule

// File: tb/test_os_tick_timer.sv
module test_os_tick_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        tick_irq;

   int n_cmp = 0;
   int n_bad = 0;
   int cycles = 0;

   bit [31:0] m_ts = 0, m_cnt = 0, m_rel = 0;
   bit        m_done = 0, m_pend = 0;

   always #2.5 clk = ~clk;

   os_tick_timer #(.CNT_W(32)) i_os_tick_timer (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_irq(tick_irq));

   function automatic bit [31:0] m_read(input bit [1:0] a);
      case (a)
         2'd0: return m_ts;
         2'd1: return m_rel;
         2'd2: return m_cnt;
         default: return {31'b0, m_pend};
      endcase
   endfunction

   task automatic step(input bit wr, input bit [1:0] a, input bit [31:0] d, input string tag);
      bit [31:0] exp_rd;
      bit n_ts_clr, n_exp, run;
      bus_wr = wr; bus_addr = a; bus_wdata = d;
      #1;
      exp_rd = m_read(a);
      n_cmp++;
      if (bus_rdata !== exp_rd) begin
         n_bad++;
         $display("FAIL %s: rdata@%0d actual %h expected %h", tag, a, bus_rdata, exp_rd);
      end
      n_cmp++;
      if (tick_irq !== m_pend) begin
         n_bad++;
         $display("FAIL R10 (%s): tick_irq actual %b expected %b", tag, tick_irq, m_pend);
      end
      @(posedge clk);
      if (!rst_n) begin
         m_ts = 0; m_cnt = 0; m_rel = 0; m_done = 0; m_pend = 0;
      end else begin
         n_ts_clr = wr && a == 2'd0;
         m_ts = n_ts_clr ? 32'd0 : m_ts + 32'd1;
         n_exp = 0;
         run = m_rel[0] && !m_done;
         if (wr && a == 2'd1) begin
            m_rel = d; m_cnt = d & ~32'd3; m_done = 0;
         end else if (run) begin
            if (m_cnt == 0) begin
               n_exp = 1;
               if (m_rel[1]) m_done = 1;
               else m_cnt = m_rel & ~32'd3;
            end else m_cnt = m_cnt - 1;
         end
         if (n_exp) m_pend = 1;
         else if (wr && a == 2'd3 && d[0]) m_pend = 0;
      end
      @(negedge clk);
   endtask

   task automatic idle(input int n, input bit [1:0] a, input string tag);
      for (int i = 0; i < n; i++) step(0, a, 0, tag);
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
         finish_run();
      end
   end

   initial begin
      @(negedge clk);
      for (int a = 0; a < 4; a++) step(0, 2'(a), 0, "R1");
      rst_n = 1'b1;
      for (int a = 0; a < 4; a++) step(0, 2'(a), 0, "R1");
      idle(6, 2'd0, "R2");
      step(1, 2'd0, 32'hDEAD_BEEF, "R3");
      idle(4, 2'd0, "R3");
      step(1, 2'd1, 32'h0000_0009, "R4");
      step(0, 2'd1, 0, "R4");
      idle(30, 2'd2, "R6");
      step(1, 2'd3, 32'h0, "R9");
      idle(2, 2'd3, "R9");
      step(1, 2'd3, 32'h1, "R9");
      idle(3, 2'd3, "R9");
      step(1, 2'd2, 32'hFFFF_FFFF, "R4");
      idle(3, 2'd2, "R4");
      step(1, 2'd1, 32'h0000_0008, "R8");
      idle(10, 2'd2, "R8");
      step(1, 2'd1, 32'h0000_0009, "R8");
      idle(12, 2'd2, "R8");
      step(1, 2'd1, 32'h0000_0011, "R5");
      idle(6, 2'd2, "R5");
      step(1, 2'd1, 32'h0000_000D, "R6");
      idle(30, 2'd2, "R6");
      step(1, 2'd3, 32'h1, "R9");
      step(1, 2'd1, 32'h0000_0007, "R7");
      idle(12, 2'd2, "R7");
      step(1, 2'd3, 32'h1, "R7");
      idle(12, 2'd3, "R7");
      step(1, 2'd1, 32'h0000_0007, "R7");
      idle(10, 2'd2, "R7");
      step(1, 2'd1, 32'h0000_0001, "R6");
      for (int i = 0; i < 3; i++) step(1, 2'd3, 32'h1, "R9");
      step(1, 2'd1, 32'h0000_0000, "R8");
      step(1, 2'd3, 32'h1, "R9");
      idle(4, 2'd3, "R10");
      idle(4, 2'd0, "R2");
      finish_run();
   end
endmodule